// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date in packed BCD. A free-running binary prescaler divides the reference clock by 2^DIV_BITS to make a one-second tick. With the default of 15 stages on a 32.768 kHz reference, the tick comes at 1 Hz. The tick passes through a carry chain: seconds, then minutes, then hours. The hour rollover steps the day of week and the date. The date rollover steps the month, and the month rollover steps the year. The hour counter runs in either a 24-hour format or a 12-hour format with a separate afternoon flag. A two-bit leap counter, stepped at every year rollover, decides whether February has 28 or 29 days.

Software sets the time by raising the stop control, which keeps the tick away from the counters. It then writes fields one at a time through a select-plus-data load port, and drops the stop control again. A separate clear control restarts the sub-second phase so that the next second starts from a known point. A busy output marks a window of reference cycles on both sides of every tick. A reader that sees busy low can take a consistent snapshot.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the block shows the following state:
  - time 00:00:00 in 24-hour format, with the afternoon flag at 0;
  - day of week 0, date 01, month 01, year 00;
  - leap counter 0, with leap detection off;
  - prescaler phase 0, so busy is 1.
- R2: The seconds field advances exactly once every 2^DIV_BITS clock cycles. After reset is released, the first advance happens at the 2^DIV_BITS-th rising edge.
- R3: Seconds and minutes count 00 to 59 in BCD. A seconds wrap advances minutes, and a minutes wrap advances hours.
- R4: In 24-hour format the hour counts 00 to 23. The step from 23 to 00 advances the date, and the day of week counts 0 to 6 and then wraps to 0.
- R5: In 12-hour format the hour runs 12, 01, 02 … 11. The step from 11 to 12 toggles the afternoon flag. The date advances only when the flag goes from 1 (afternoon) to 0 (morning).
- R6: In 24-hour format the afternoon flag always reads 0, even if a write sets its bit.
- R7: The last day of a month is:
  - 30 for months 04, 06, 09 and 11;
  - 31 for the other months except February.

  After the last day the date returns to 01 and the month advances. Month 12 returns to 01 and advances the year in BCD, with 99 wrapping to 00.
- R8: February ends at 29 when leap detection is on and the leap counter is 0. Otherwise February ends at 28.
- R9: The leap counter advances modulo 4 at every year rollover. A leap-field write always sets detection from data bit 3. It loads the counter from bits 1:0 only when bit 2 of the same write is 1.
- R10: A write (ld_we_i high) updates the field chosen by ld_sel_i:
  - 0: seconds
  - 1: minutes
  - 2: hour, with bit 7 as the 12-hour format flag, bit 6 as the afternoon flag and bits 5:0 as the BCD hour
  - 3: day of week
  - 4: date
  - 5: month
  - 6: year
  - 7: leap control

  A value with a non-decimal digit, or outside the field's legal range, is ignored and leaves the field unchanged. The legal ranges are 00–59, 01–12 or 00–23 for the hour depending on format, 0–6, 01–31, 01–12 and 00–99.
- R11: While hold_i is 1, no field advances. The prescaler phase keeps running.
- R12: When clr_i is 1 at a rising edge, the phase returns to 0 and no tick is made at that edge. The next advance comes 2^DIV_BITS edges after that edge.
- R13: busy_o is 1 while the phase is among the last BUSY_PRE values before a tick, or among the first BUSY_POST values after it. busy_o is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Stop: keeps the second tick away from the counters |
| clr_i | input | 1 | Restarts the sub-second prescaler phase |
| ld_we_i | input | 1 | Field write strobe |
| ld_sel_i | input | 3 | Field select |
| ld_data_i | input | 8 | Field write value |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hour, BCD |
| mode12_o | output | 1 | 1 = 12-hour format |
| pm_o | output | 1 | Afternoon flag |
| dow_o | output | 3 | Day of week 0..6 |
| date_o | output | 6 | Date, BCD |
| month_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| leap_cnt_o | output | 2 | Leap counter |
| leap_det_o | output | 1 | Leap detection enable |
| busy_o | output | 1 | Tick window indication |

## Verification
The carry chain is driven from loaded start points placed just before each boundary:
- A minute rollover and a midnight step.
- February 28 with detection on and with detection off. This separates the 28-day and 29-day February paths.
- April 30 and December 31 of year 99, which exercise the 30-day months and the year and leap-counter wrap.

In 12-hour format, three start points separate the afternoon toggle from the date step:
- 11 AM
- 11 PM
- 12 AM

Invalid digits, out-of-range values and a leap write without its permit bit show that rejected writes change nothing. Hold and clear sequences separate tick gating from phase restart, and the busy window is sampled at chosen phase values.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Field select codes for the load port
  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_LEAP  = 3'd7
  } fld_e;

  // Packed-BCD increment of a two-digit value (no range wrap)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Both digits decimal and value inside [lo, hi]; BCD order equals numeric order
  function automatic logic bcd_in_range(input logic [7:0] v,
                                        input logic [7:0] lo,
                                        input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS  = 15,
  parameter int BUSY_PRE  = 2,
  parameter int BUSY_POST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic clr_i,
  output logic tick_o,
  output logic busy_o
);

  localparam int                  PHASE_TOP = (1 << DIV_BITS) - 1;
  localparam logic [DIV_BITS-1:0] PH_MAX    = DIV_BITS'(PHASE_TOP);
  localparam logic [DIV_BITS-1:0] PH_ONE    = DIV_BITS'(1);

  logic [DIV_BITS-1:0] phase_q, phase_d;
  logic                pre_win, post_win;

  always_comb begin
    if (clr_i) phase_d = '0;
    else       phase_d = phase_q + PH_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign tick_o = (phase_q == PH_MAX) && !hold_i && !clr_i;

  generate
    if (BUSY_PRE > 0) begin : g_pre
      localparam logic [DIV_BITS-1:0] PRE_START = DIV_BITS'(PHASE_TOP - BUSY_PRE + 1);
      assign pre_win = (phase_q >= PRE_START);
    end else begin : g_nopre
      assign pre_win = 1'b0;
    end
    if (BUSY_POST > 0) begin : g_post
      localparam logic [DIV_BITS-1:0] POST_END = DIV_BITS'(BUSY_POST);
      assign post_win = (phase_q < POST_END);
    end else begin : g_nopost
      assign post_win = 1'b0;
    end
  endgenerate

  assign busy_o = pre_win | post_win;

  // R13: the counters never move outside the busy window
  a_r13_busy_covers_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> busy_o);
  // R2: ticks are never on adjacent cycles
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R11: stop control blocks the tick
  a_r11_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> !tick_o);
  // R12: a phase clear is never followed directly by a tick
  a_r12_clr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !tick_o);

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       we_sec_i,
  input  logic       we_min_i,
  input  logic       we_hour_i,
  input  logic [7:0] wdata_i,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic       mode12_o,
  output logic       pm_o,
  output logic       day_tick_o
);

  logic [7:0] sec_q, sec_d, min_q, min_d;
  logic [5:0] hour_q, hour_d;
  logic       mode12_q, mode12_d, pm_q, pm_d;
  logic       sec_wrap, min_step, min_wrap, hour_step;
  logic       sec_ok, min_ok, hour_ok;

  assign sec_wrap  = tick_i && (sec_q == 8'h59);
  assign min_step  = sec_wrap;
  assign min_wrap  = min_step && (min_q == 8'h59);
  assign hour_step = min_wrap;

  assign sec_ok  = bcd_in_range(wdata_i, 8'h00, 8'h59);
  assign min_ok  = sec_ok;
  assign hour_ok = wdata_i[7] ? bcd_in_range({2'b00, wdata_i[5:0]}, 8'h01, 8'h12)
                              : bcd_in_range({2'b00, wdata_i[5:0]}, 8'h00, 8'h23);

  assign day_tick_o = hour_step && (mode12_q ? (pm_q && (hour_q == 6'h11))
                                             : (hour_q == 6'h23));

  always_comb begin
    sec_d = sec_q;
    if (we_sec_i && sec_ok)  sec_d = wdata_i;
    else if (tick_i)         sec_d = sec_wrap ? 8'h00 : bcd_inc(sec_q);

    min_d = min_q;
    if (we_min_i && min_ok)  min_d = wdata_i;
    else if (min_step)       min_d = min_wrap ? 8'h00 : bcd_inc(min_q);

    hour_d   = hour_q;
    mode12_d = mode12_q;
    pm_d     = pm_q;
    if (we_hour_i && hour_ok) begin
      hour_d   = wdata_i[5:0];
      mode12_d = wdata_i[7];
      pm_d     = wdata_i[7] & wdata_i[6];
    end else if (hour_step) begin
      if (mode12_q) begin
        if (hour_q == 6'h12) begin
          hour_d = 6'h01;
        end else if (hour_q == 6'h11) begin
          hour_d = 6'h12;
          pm_d   = ~pm_q;
        end else begin
          hour_d = 6'(bcd_inc({2'b00, hour_q}));
        end
      end else begin
        hour_d = (hour_q == 6'h23) ? 6'h00 : 6'(bcd_inc({2'b00, hour_q}));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q    <= 8'h00;
      min_q    <= 8'h00;
      hour_q   <= 6'h00;
      mode12_q <= 1'b0;
      pm_q     <= 1'b0;
    end else begin
      sec_q    <= sec_d;
      min_q    <= min_d;
      hour_q   <= hour_d;
      mode12_q <= mode12_d;
      pm_q     <= pm_d;
    end
  end

  assign sec_o    = sec_q[6:0];
  assign min_o    = min_q[6:0];
  assign hour_o   = hour_q;
  assign mode12_o = mode12_q;
  assign pm_o     = pm_q;

  // R3: seconds and minutes stay legal BCD 00..59
  a_r3_sec_digits: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[3:0] <= 4'd9) && (sec_q[7:4] <= 4'd5));
  a_r3_min_digits: assert property (@(posedge clk) disable iff (!rst_n)
    (min_q[3:0] <= 4'd9) && (min_q[7:4] <= 4'd5));
  // R6: no afternoon flag in 24-hour format
  a_r6_pm_24h: assert property (@(posedge clk) disable iff (!rst_n)
    !mode12_q |-> !pm_q);
  // R5: 12-hour format never shows hour zero
  a_r5_no_zero_hour: assert property (@(posedge clk) disable iff (!rst_n)
    mode12_q |-> (hour_q != 6'h00));
  // R11: without a tick or a write the seconds hold
  a_r11_sec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !we_sec_i) |=> $stable(sec_q));
  // R4: midnight in 24-hour format
  a_r4_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !mode12_q && hour_q == 6'h23 && min_q == 8'h59 && sec_q == 8'h59 &&
     !we_hour_i && !we_min_i && !we_sec_i) |=> (hour_q == 6'h00));

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_tick_i,
  input  logic       we_dow_i,
  input  logic       we_date_i,
  input  logic       we_month_i,
  input  logic       we_year_i,
  input  logic       we_leap_i,
  input  logic [7:0] wdata_i,
  output logic [2:0] dow_o,
  output logic [5:0] date_o,
  output logic [4:0] month_o,
  output logic [7:0] year_o,
  output logic [1:0] leap_cnt_o,
  output logic       leap_det_o
);

  logic [2:0] dow_q, dow_d;
  logic [5:0] date_q, date_d;
  logic [4:0] month_q, month_d;
  logic [7:0] year_q, year_d;
  logic [1:0] leap_q, leap_d;
  logic       ldet_q, ldet_d;
  logic       leap_yr, month_step, year_step;
  logic [5:0] last_day;

  assign leap_yr = ldet_q && (leap_q == 2'd0);

  always_comb begin
    case (month_q)
      5'h02:                       last_day = leap_yr ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11:  last_day = 6'h30;
      default:                     last_day = 6'h31;
    endcase
  end

  assign month_step = day_tick_i && (date_q >= last_day);
  assign year_step  = month_step && (month_q == 5'h12);

  always_comb begin
    dow_d = dow_q;
    if (we_dow_i && (wdata_i <= 8'd6)) dow_d = wdata_i[2:0];
    else if (day_tick_i)               dow_d = (dow_q == 3'd6) ? 3'd0 : dow_q + 3'd1;

    date_d = date_q;
    if (we_date_i && bcd_in_range(wdata_i, 8'h01, 8'h31)) date_d = wdata_i[5:0];
    else if (day_tick_i) date_d = month_step ? 6'h01 : 6'(bcd_inc({2'b00, date_q}));

    month_d = month_q;
    if (we_month_i && bcd_in_range(wdata_i, 8'h01, 8'h12)) month_d = wdata_i[4:0];
    else if (month_step) month_d = year_step ? 5'h01 : 5'(bcd_inc({3'b000, month_q}));

    year_d = year_q;
    if (we_year_i && bcd_in_range(wdata_i, 8'h00, 8'h99)) year_d = wdata_i;
    else if (year_step) year_d = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);

    ldet_d = ldet_q;
    leap_d = leap_q;
    if (we_leap_i) begin
      ldet_d = wdata_i[3];
      if (wdata_i[2]) leap_d = wdata_i[1:0];
    end else if (year_step) begin
      leap_d = leap_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q   <= 3'd0;
      date_q  <= 6'h01;
      month_q <= 5'h01;
      year_q  <= 8'h00;
      leap_q  <= 2'd0;
      ldet_q  <= 1'b0;
    end else begin
      dow_q   <= dow_d;
      date_q  <= date_d;
      month_q <= month_d;
      year_q  <= year_d;
      leap_q  <= leap_d;
      ldet_q  <= ldet_d;
    end
  end

  assign dow_o      = dow_q;
  assign date_o     = date_q;
  assign month_o    = month_q;
  assign year_o     = year_q;
  assign leap_cnt_o = leap_q;
  assign leap_det_o = ldet_q;

  // R4: day of week stays in 0..6
  a_r4_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
    dow_q <= 3'd6);
  // R7: a month change not caused by a write lands on the first
  a_r7_month_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((month_q != $past(month_q)) && !$past(we_month_i)) |-> (date_q == 6'h01));
  // R9: year rollover steps the leap counter by one
  a_r9_leap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (year_step && !we_leap_i) |=> (leap_q == $past(leap_q) + 2'd1));
  // R8: common-year February ends on the 28th
  a_r8_feb_short: assert property (@(posedge clk) disable iff (!rst_n)
    (day_tick_i && month_q == 5'h02 && date_q == 6'h28 && !leap_yr &&
     !we_date_i && !we_month_i) |=> (date_q == 6'h01 && month_q == 5'h03));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DIV_BITS  = 15,
  parameter int BUSY_PRE  = 2,
  parameter int BUSY_POST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_i,
  input  logic       clr_i,
  input  logic       ld_we_i,
  input  logic [2:0] ld_sel_i,
  input  logic [7:0] ld_data_i,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic       mode12_o,
  output logic       pm_o,
  output logic [2:0] dow_o,
  output logic [5:0] date_o,
  output logic [4:0] month_o,
  output logic [7:0] year_o,
  output logic [1:0] leap_cnt_o,
  output logic       leap_det_o,
  output logic       busy_o
);

  localparam int NUM_FIELDS = 8;

  logic [NUM_FIELDS-1:0] we_vec;
  logic                  tick_w, day_tick_w;

  assign we_vec = ld_we_i ? (NUM_FIELDS'(1) << ld_sel_i) : '0;

  rtc_prescaler #(
    .DIV_BITS (DIV_BITS),
    .BUSY_PRE (BUSY_PRE),
    .BUSY_POST(BUSY_POST)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (hold_i),
    .clr_i  (clr_i),
    .tick_o (tick_w),
    .busy_o (busy_o)
  );

  rtc_time_chain u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_w),
    .we_sec_i   (we_vec[FLD_SEC]),
    .we_min_i   (we_vec[FLD_MIN]),
    .we_hour_i  (we_vec[FLD_HOUR]),
    .wdata_i    (ld_data_i),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o),
    .mode12_o   (mode12_o),
    .pm_o       (pm_o),
    .day_tick_o (day_tick_w)
  );

  rtc_date_chain u_date (
    .clk        (clk),
    .rst_n      (rst_n),
    .day_tick_i (day_tick_w),
    .we_dow_i   (we_vec[FLD_DOW]),
    .we_date_i  (we_vec[FLD_DATE]),
    .we_month_i (we_vec[FLD_MONTH]),
    .we_year_i  (we_vec[FLD_YEAR]),
    .we_leap_i  (we_vec[FLD_LEAP]),
    .wdata_i    (ld_data_i),
    .dow_o      (dow_o),
    .date_o     (date_o),
    .month_o    (month_o),
    .year_o     (year_o),
    .leap_cnt_o (leap_cnt_o),
    .leap_det_o (leap_det_o)
  );

  // R10: a seconds write with a non-decimal low digit changes nothing
  a_r10_bad_sec_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we_i && ld_sel_i == 3'd0 && ld_data_i[3:0] > 4'd9 && !tick_w) |=> $stable(sec_o));
  // R10: an out-of-range month write changes nothing
  a_r10_bad_month_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we_i && ld_sel_i == 3'd5 && ld_data_i > 8'h12 && !day_tick_w) |=> $stable(month_o));

endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;

  localparam int DIVB = 4;
  localparam int P    = 1 << DIVB;
  localparam int PRE  = 2;
  localparam int POST = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold = 1'b0, clr = 1'b0, ld_we = 1'b0;
  logic [2:0] ld_sel = 3'd0;
  logic [7:0] ld_data = 8'd0;
  logic [6:0] sec_o, min_o;
  logic [5:0] hour_o, date_o;
  logic       mode12_o, pm_o, leap_det_o, busy_o;
  logic [2:0] dow_o;
  logic [4:0] month_o;
  logic [7:0] year_o;
  logic [1:0] leap_cnt_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state (decimal values)
  int m_phase, m_sec, m_min, m_hr, m_dow, m_date, m_month, m_year, m_leap;
  bit m12, m_pm, m_det;

  always #5 clk = ~clk;

  rtc_calendar #(.DIV_BITS(DIVB), .BUSY_PRE(PRE), .BUSY_POST(POST)) uut (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .clr_i(clr),
    .ld_we_i(ld_we), .ld_sel_i(ld_sel), .ld_data_i(ld_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .mode12_o(mode12_o), .pm_o(pm_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .leap_cnt_o(leap_cnt_o), .leap_det_o(leap_det_o), .busy_o(busy_o)
  );

  function automatic int to_bcd(int v);
    return ((v / 10) * 16) + (v % 10);
  endfunction

  function automatic int from_bcd(int v);
    return ((v / 16) * 10) + (v % 16);
  endfunction

  function automatic bit bcd_ok(int v, int lo, int hi);
    if ((v % 16) > 9 || (v / 16) > 9) return 0;
    return (from_bcd(v) >= lo) && (from_bcd(v) <= hi);
  endfunction

  function automatic int m_days();
    if (m_month == 2) return (m_det && m_leap == 0) ? 29 : 28;
    if (m_month == 4 || m_month == 6 || m_month == 9 || m_month == 11) return 30;
    return 31;
  endfunction

  task automatic m_reset();
    m_phase = 0; m_sec = 0; m_min = 0; m_hr = 0; m12 = 0; m_pm = 0;
    m_dow = 0; m_date = 1; m_month = 1; m_year = 0; m_leap = 0; m_det = 0;
  endtask

  task automatic m_day();
    m_dow = (m_dow + 1) % 7;
    m_date++;
    if (m_date > m_days()) begin
      m_date = 1;
      m_month++;
      if (m_month > 12) begin
        m_month = 1;
        m_year = (m_year + 1) % 100;
        m_leap = (m_leap + 1) % 4;
      end
    end
  endtask

  task automatic m_second();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0;
    m_min++;
    if (m_min < 60) return;
    m_min = 0;
    if (!m12) begin
      m_hr++;
      if (m_hr == 24) begin m_hr = 0; m_day(); end
    end else if (m_hr == 11) begin
      m_hr = 12;
      if (m_pm) begin m_pm = 0; m_day(); end
      else m_pm = 1;
    end else if (m_hr == 12) m_hr = 1;
    else m_hr++;
  endtask

  task automatic m_load(int sel, int d);
    case (sel)
      0: if (bcd_ok(d, 0, 59)) m_sec = from_bcd(d);
      1: if (bcd_ok(d, 0, 59)) m_min = from_bcd(d);
      2: begin
        int hv;
        bit md;
        hv = d % 64;
        md = (d / 128) % 2;
        if (md ? bcd_ok(hv, 1, 12) : bcd_ok(hv, 0, 23)) begin
          m12 = md; m_pm = md && ((d / 64) % 2 == 1); m_hr = from_bcd(hv);
        end
      end
      3: if (d <= 6) m_dow = d;
      4: if (bcd_ok(d, 1, 31)) m_date = from_bcd(d);
      5: if (bcd_ok(d, 1, 12)) m_month = from_bcd(d);
      6: if (bcd_ok(d, 0, 99)) m_year = from_bcd(d);
      default: begin
        m_det = ((d / 8) % 2) == 1;
        if ((d / 4) % 2 == 1) m_leap = d % 4;
      end
    endcase
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      bit tk;
      tk = (m_phase == P - 1) && !hold && !clr;
      m_phase = clr ? 0 : (m_phase + 1) % P;
      if (ld_we) m_load(int'(ld_sel), int'(ld_data));
      if (tk) m_second();
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 seconds", int'(sec_o), to_bcd(m_sec));
      chk("R3 minutes", int'(min_o), to_bcd(m_min));
      chk("R4 hour", int'(hour_o), to_bcd(m_hr));
      chk("R5 format", int'(mode12_o), int'(m12));
      chk("R5 afternoon", int'(pm_o), int'(m_pm));
      chk("R4 weekday", int'(dow_o), m_dow);
      chk("R7 date", int'(date_o), to_bcd(m_date));
      chk("R7 month", int'(month_o), to_bcd(m_month));
      chk("R7 year", int'(year_o), to_bcd(m_year));
      chk("R9 leap count", int'(leap_cnt_o), m_leap);
      chk("R9 leap detect", int'(leap_det_o), int'(m_det));
      chk("R13 busy", int'(busy_o), int'((m_phase >= P - PRE) || (m_phase < POST)));
    end
  end

  task automatic wr(int sel, int d);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = 3'(sel); ld_data = 8'(d);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic set_hms(int h, int m, int s);
    wr(2, h); wr(1, m); wr(0, s);
  endtask

  task automatic run_secs(int n);
    hold = 1'b0;
    repeat (n * P) @(negedge clk);
    hold = 1'b1;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int d0, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 sec", int'(sec_o), 0);
    chk("R1 hour", int'(hour_o), 0);
    chk("R1 date", int'(date_o), 1);
    chk("R1 month", int'(month_o), 1);
    chk("R1 year", int'(year_o), 0);
    chk("R1 busy", int'(busy_o), 1);
    // R2 / R13 timing of the first second
    repeat (2) @(negedge clk);
    chk("R13 busy off mid-phase", int'(busy_o), 0);
    repeat (12) @(negedge clk);
    chk("R13 busy before tick", int'(busy_o), 1);
    @(negedge clk);
    chk("R2 no advance before period", int'(sec_o), 0);
    @(negedge clk);
    chk("R2 first advance", int'(sec_o), 1);

    // R3 minute rollover
    hold = 1'b1;
    set_hms(8'h10, 8'h59, 8'h59);
    run_secs(1);
    chk("R3 hour after carry", int'(hour_o), 8'h11);
    chk("R3 minute wrap", int'(min_o), 0);

    // R8 detection off: Feb 28 -> Mar 01, R4 midnight
    wr(7, 8'h04); wr(6, 8'h23); wr(5, 8'h02); wr(4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h58);
    run_secs(2);
    chk("R8 common feb month", int'(month_o), 3);
    chk("R8 common feb date", int'(date_o), 1);
    chk("R4 midnight hour", int'(hour_o), 0);
    chk("R4 weekday step", int'(dow_o), 1);

    // R8 detection on: Feb 28 -> 29 -> Mar 01
    wr(7, 8'h0C); wr(5, 8'h02); wr(4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59);
    run_secs(1);
    chk("R8 leap feb 29", int'(date_o), 8'h29);
    set_hms(8'h23, 8'h59, 8'h59);
    run_secs(1);
    chk("R8 leap feb end month", int'(month_o), 3);
    chk("R8 leap feb end date", int'(date_o), 1);

    // R5 twelve-hour sequence
    d0 = int'(date_o);
    set_hms(8'h91, 8'h59, 8'h59);
    run_secs(1);
    chk("R5 11am to 12pm hour", int'(hour_o), 8'h12);
    chk("R5 11am to 12pm flag", int'(pm_o), 1);
    chk("R5 noon keeps date", int'(date_o), d0);
    set_hms(8'hD1, 8'h59, 8'h59);
    run_secs(1);
    chk("R5 11pm to 12am flag", int'(pm_o), 0);
    chk("R5 midnight advances date", int'(date_o), 8'h02);
    set_hms(8'h92, 8'h59, 8'h59);
    run_secs(1);
    chk("R5 12 to 01", int'(hour_o), 1);

    // R6 afternoon bit ignored in 24-hour format
    wr(2, 8'h45);
    chk("R6 format", int'(mode12_o), 0);
    chk("R6 flag", int'(pm_o), 0);
    chk("R6 hour", int'(hour_o), 5);

    // R10 rejected writes
    wr(0, 8'h30); wr(3, 4);
    wr(0, 8'h60);
    chk("R10 sec 60 ignored", int'(sec_o), 8'h30);
    wr(0, 8'h3A);
    chk("R10 sec bad digit ignored", int'(sec_o), 8'h30);
    wr(2, 8'h24);
    chk("R10 hour 24 ignored", int'(hour_o), 5);
    wr(2, 8'h80);
    chk("R10 12h hour 00 ignored", int'(mode12_o), 0);
    wr(5, 8'h13);
    chk("R10 month 13 ignored", int'(month_o), 3);
    wr(4, 8'h00);
    chk("R10 date 00 ignored", int'(date_o), 8'h02);
    wr(3, 7);
    chk("R10 weekday 7 ignored", int'(dow_o), 4);

    // R9 counter write needs its permit bit
    wr(7, 8'h0B);
    chk("R9 no permit keeps count", int'(leap_cnt_o), 0);
    chk("R9 detect set", int'(leap_det_o), 1);

    // R7 / R9 year rollover
    wr(7, 8'h07); wr(6, 8'h99); wr(5, 8'h12); wr(4, 8'h31);
    set_hms(8'h23, 8'h59, 8'h59);
    run_secs(1);
    chk("R7 year wrap", int'(year_o), 0);
    chk("R7 month wrap", int'(month_o), 1);
    chk("R9 leap count wrap", int'(leap_cnt_o), 0);

    // R7 thirty-day month
    wr(5, 8'h04); wr(4, 8'h30);
    set_hms(8'h23, 8'h59, 8'h59);
    run_secs(1);
    chk("R7 april end month", int'(month_o), 5);
    chk("R7 april end date", int'(date_o), 1);

    // R11 hold freezes time
    s0 = int'(sec_o);
    repeat (3 * P) @(negedge clk);
    chk("R11 held seconds", int'(sec_o), s0);

    // R12 phase clear
    hold = 1'b0;
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R13 busy after clear", int'(busy_o), 1);
    s0 = int'(sec_o);
    repeat (P - 1) @(negedge clk);
    chk("R12 no tick before full period", int'(sec_o), s0);
    @(negedge clk);
    chk("R12 tick after full period", int'(sec_o), to_bcd(from_bcd(s0) + 1));

    run_secs(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule